// File: doc/BRIEF.md
# Double-Buffered Carrier Phase Generator

This block produces the running phase of a carrier oscillator. A 32-bit phase accumulator adds the active frequency word on every cycle in which the step enable is high. The output phase is the top 10 bits of that accumulator plus an active 10-bit phase offset. The sine/cosine lookup and the mixer sit downstream and are not part of this block.

The frequency word and the phase offset are double-buffered. A processor first writes new values into holding registers, and these writes do not affect the running oscillator. The held values reach the active registers in one of two ways.

- **Strobe addresses.** Each register has its own strobe address. Writing to the frequency strobe copies the held frequency, and writing to the phase strobe copies the held offset.
- **Sync pulse.** An external sync pulse copies both held values at once. The pulse only counts while the sync-enable control bit is high.

Every transfer is aligned to an oscillator step. A request made while stepping is stalled is remembered, and it is applied at the next enabled cycle. A request made during an enabled cycle is applied at the edge that ends that cycle.

Top module: `carrier_nco`

## Requirements
- R1: After reset, all holding registers, active registers, the accumulator and the pending flags are zero, so `phase_out` is 0.
- R2: Writes to the holding addresses leave the active registers unchanged. The write addresses are `wr_sel` 0 for the held frequency (`wr_data[31:0]`) and 1 for the held offset (`wr_data[9:0]`). While no transfer is requested, `phase_out` keeps following the old active values.
- R3: A write to `wr_sel` 2 (the frequency strobe) requests a copy of the held frequency into the active frequency. The copy takes effect at the first enabled edge. That edge still adds the previous active frequency, and the following steps add the new one.
- R4: A write to `wr_sel` 3 (the phase strobe) requests a copy of the held offset into the active offset. The copy takes effect at the first enabled edge.
- R5: While `sync_en` is 1, a cycle with `sync_in` high requests both transfers. They take effect together at the first enabled edge.
- R6: While `sync_en` is 0, `sync_in` has no effect on the active registers.
- R7: On a cycle with `step_en` low, the accumulator and both active registers hold their values, so `phase_out` is stable.
- R8: A sync request made while `step_en` is low is held pending through any number of stalled cycles. It is applied at the next enabled edge.
- R9: A strobe request made while `step_en` is low is also held pending and applied at the next enabled edge.
- R10: `phase_out` equals `acc[31:22]` plus the active offset, taken modulo 1024. Each enabled edge adds the active frequency to `acc`, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Processor write strobe, one cycle per write |
| wr_sel | input | 2 | Write target: 0 held frequency, 1 held offset, 2 frequency strobe, 3 phase strobe |
| wr_data | input | 32 | Write data |
| sync_en | input | 1 | Control bit that lets `sync_in` trigger transfers |
| sync_in | input | 1 | External sync pulse |
| step_en | input | 1 | Oscillator advance enable |
| phase_out | output | 10 | Offset-adjusted carrier phase |

## Verification
The bench stalls the oscillator around strobe and sync requests. A design that dropped a stalled request would never change its output, and one that applied the request at once would show the new offset before any step. It also issues a strobe in the same cycle as an enabled step; a design that added the newly loaded frequency at that edge would come out one step ahead. Further tests pulse sync while `sync_en` is low, where a leaky gate would load the offset, and run the phase offset past 1023, where a wrong output width or a missing wrap would not return to a small value.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned FREQ_W = 32;
  localparam int unsigned PH_W   = 10;
  localparam int unsigned SEL_W  = 2;

  localparam logic [SEL_W-1:0] SEL_HOLD_FREQ = 2'd0;
  localparam logic [SEL_W-1:0] SEL_HOLD_PH   = 2'd1;
  localparam logic [SEL_W-1:0] SEL_STB_FREQ  = 2'd2;
  localparam logic [SEL_W-1:0] SEL_STB_PH    = 2'd3;
endpackage

// File: rtl/nco_regs.sv
module nco_regs
  import nco_pkg::*;
#(
  parameter int unsigned FW = FREQ_W,
  parameter int unsigned PW = PH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [FW-1:0]    wr_data,
  input  logic             sync_en,
  input  logic             sync_in,
  input  logic             step_en,
  output logic [FW-1:0]    act_freq,
  output logic [PW-1:0]    act_ph
);
  logic [FW-1:0] hold_freq;
  logic [PW-1:0] hold_ph;
  logic          pend_freq, pend_ph;
  logic          stb_freq, stb_ph, sync_hit;
  logic          req_freq, req_ph;

  assign stb_freq = wr_en && (wr_sel == SEL_STB_FREQ);
  assign stb_ph   = wr_en && (wr_sel == SEL_STB_PH);
  assign sync_hit = sync_in && sync_en;
  assign req_freq = pend_freq || stb_freq || sync_hit;
  assign req_ph   = pend_ph   || stb_ph   || sync_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_freq <= '0;
      hold_ph   <= '0;
      act_freq  <= '0;
      act_ph    <= '0;
      pend_freq <= 1'b0;
      pend_ph   <= 1'b0;
    end else begin
      if (wr_en && (wr_sel == SEL_HOLD_FREQ)) hold_freq <= wr_data;
      if (wr_en && (wr_sel == SEL_HOLD_PH))   hold_ph   <= wr_data[PW-1:0];
      if (step_en && req_freq) act_freq <= hold_freq;
      if (step_en && req_ph)   act_ph   <= hold_ph;
      pend_freq <= req_freq && !step_en;
      pend_ph   <= req_ph   && !step_en;
    end
  end

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(act_freq) && $stable(act_ph)));

  // R8
  sync_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && sync_en && !step_en) |=> (pend_freq && pend_ph));

  // R3
  freq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && pend_freq) |=> (act_freq == $past(hold_freq)));

  // R4
  ph_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && pend_ph) |=> (act_ph == $past(hold_ph)));
endmodule

// File: rtl/nco_accum.sv
module nco_accum
  import nco_pkg::*;
#(
  parameter int unsigned FW = FREQ_W,
  parameter int unsigned PW = PH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic [FW-1:0] act_freq,
  input  logic [PW-1:0] act_ph,
  output logic [PW-1:0] phase_out
);
  localparam int unsigned TOP = FW - 1;

  logic [FW-1:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else if (step_en) acc <= acc + act_freq;
  end

  assign phase_out = acc[TOP -: PW] + act_ph;

  // R7
  acc_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(acc));

  // R10
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (acc == $past(acc) + $past(act_freq)));
endmodule

// File: rtl/carrier_nco.sv
module carrier_nco
  import nco_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [FREQ_W-1:0] wr_data,
  input  logic             sync_en,
  input  logic             sync_in,
  input  logic             step_en,
  output logic [PH_W-1:0]  phase_out
);
  logic [FREQ_W-1:0] act_freq;
  logic [PH_W-1:0]   act_ph;

  nco_regs #(.FW(FREQ_W), .PW(PH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sync_en(sync_en), .sync_in(sync_in),
    .step_en(step_en), .act_freq(act_freq), .act_ph(act_ph)
  );

  nco_accum #(.FW(FREQ_W), .PW(PH_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .act_freq(act_freq),
    .act_ph(act_ph), .phase_out(phase_out)
  );

  // R7
  phase_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(phase_out));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (phase_out == '0));
endmodule

// File: tb/test_carrier_nco.sv
module test_carrier_nco;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        sync_en = 1'b0;
  logic        sync_in = 1'b0;
  logic        step_en = 1'b0;
  logic [9:0]  phase_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] ONE = 32'h0040_0000; // one output LSB per step

  always #4 clk = ~clk;

  carrier_nco i_carrier_nco (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sync_en(sync_en), .sync_in(sync_in),
    .step_en(step_en), .phase_out(phase_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: phase_out got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; sync_in = 1'b0; step_en = 1'b0; sync_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic steps(input int n);
    @(negedge clk);
    step_en = 1'b1;
    repeat (n) @(negedge clk);
    step_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sync();
    @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1", phase_out, 0);
  endtask

  task automatic t_hold_only();
    do_reset();
    wr(2'd0, ONE);
    wr(2'd1, 32'd5);
    steps(3);
    chk("R2", phase_out, 0);
  endtask

  task automatic t_freq_strobe();
    do_reset();
    wr(2'd0, ONE);
    wr(2'd2, 32'd0);
    idle(2);
    chk("R9", phase_out, 0);
    steps(1);
    chk("R3", phase_out, 0);
    steps(3);
    chk("R3", phase_out, 3);
  endtask

  task automatic t_phase_strobe();
    do_reset();
    wr(2'd1, 32'd100);
    wr(2'd3, 32'd0);
    chk("R9", phase_out, 0);
    steps(1);
    chk("R4", phase_out, 100);
  endtask

  task automatic t_sync();
    do_reset();
    wr(2'd0, 2 * ONE);
    wr(2'd1, 32'd7);
    sync_en = 1'b1;
    pulse_sync();
    idle(3);
    chk("R8", phase_out, 0);
    steps(1);
    chk("R5", phase_out, 7);
    steps(2);
    chk("R5", phase_out, 11);
  endtask

  task automatic t_sync_off();
    do_reset();
    wr(2'd0, ONE);
    wr(2'd1, 32'd9);
    sync_en = 1'b0;
    pulse_sync();
    steps(3);
    chk("R6", phase_out, 0);
  endtask

  task automatic t_wrap_stall();
    do_reset();
    wr(2'd0, ONE);
    wr(2'd1, 32'd1020);
    sync_en = 1'b1;
    pulse_sync();
    steps(1);
    chk("R10", phase_out, 1020);
    steps(5);
    chk("R10", phase_out, 1);
    idle(5);
    chk("R7", phase_out, 1);
  endtask

  task automatic t_live_strobe();
    do_reset();
    wr(2'd0, ONE);
    @(negedge clk);
    step_en = 1'b1; wr_en = 1'b1; wr_sel = 2'd2; wr_data = '0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R3", phase_out, 0);
    idle(2);
    step_en = 1'b0;
    chk("R3", phase_out, 2);
  endtask

  initial begin
    t_reset();
    t_hold_only();
    t_freq_strobe();
    t_phase_strobe();
    t_sync();
    t_sync_off();
    t_wrap_stall();
    t_live_strobe();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule